// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns one indexed-addressing request into a 16-bit effective address. A request carries a postbyte, up to two extension bytes, the current X, Y, SP and PC registers, and the two 8-bit accumulators A and B. The 16-bit accumulator D is the pair {A, B}, with A as the high byte. The postbyte picks a base register and one of five address-forming schemes: a short signed constant, a 9-bit or 16-bit constant, an auto-increment or auto-decrement of the base, an accumulator offset, or a memory-indirect form. The memory-indirect form reads a 16-bit pointer from memory.

The result reports several things: the effective address, how many extension bytes the encoding used, and a writeback of the base register for the auto-update forms. When the request asks for it, the result also carries a load of the address into an index register. A request that names an impossible load target is flagged as illegal.

Three valid/ready channels connect the block. Requests enter on `req_*`, and the block accepts one only while it is idle. Results leave on `res_*`. A result stays valid and unchanged until the consumer raises `res_ready`, so a stalled consumer simply holds the block. Indirect forms issue byte reads on `rd_*`. Each read holds its address until `rd_ready`, and the returned byte is taken from `rd_data` in the cycle of that handshake.

Top module: `ieag_top`

## Requirements
- R1: Postbyte `rr0nnnnn` adds the 5-bit two's-complement value nnnnn (−16..+15) to the base. It uses 0 extension bytes. The base field rr is 00=X, 01=Y, 10=SP, 11=PC.
- R2: Postbyte `111rr00s` adds a 9-bit signed offset. Its sign is bit 0 of the postbyte, and its low eight bits are the first extension byte. It uses 1 extension byte.
- R3: Postbyte `111rr010` adds a 16-bit offset, with the first extension byte as the high byte and the second as the low byte. It uses 2 extension bytes. The reported byte count is never 3.
- R4: Postbyte `rr1pnnnn` with rr≠11 is auto-update. The amount is nnnn+1 when bit 3 is 0 (+1..+8) and nnnn−16 when bit 3 is 1 (−8..−1). When p=0 (bit 4) the effective address is the updated value; when p=1 it is the original base. The result writes base+amount back to the base register, and the writeback select is never 11. It uses 0 extension bytes.
- R5: Postbyte `111rr1aa` with aa=00 adds A zero-extended, with aa=01 adds B zero-extended, and with aa=10 adds D. It uses 0 extension bytes.
- R6: The two indirect forms are `111rr011`, with a 16-bit offset and 2 extension bytes, and `111rr111`, with offset D and 0 extension bytes. Each reads byte pointer and then byte pointer+1. The first byte is the high byte of the effective address. Indirect forms never write back.
- R7: With PC as the base, the value used is PC+1+(extension byte count), where PC is the address of the postbyte.
- R8: All address sums wrap modulo 2^16.
- R9: With `req_lea` set, the result reports a load of the effective address into the register `req_lea_dst` (00=X, 01=Y, 10=SP). Destination 11 sets `res_illegal` and suppresses the load. A load into the same register as an auto-update writeback cancels that writeback.
- R10: `req_ready` is high only while no request is in progress. A result held under back-pressure keeps every `res_*` field stable. A read held under back-pressure keeps `rd_addr` stable. `rd_valid` and `res_valid` are never high together.
- R11: After reset, `req_ready` is 1 and both `res_valid` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_postbyte | input | 8 | Addressing postbyte |
| req_ext0 | input | 8 | First extension byte |
| req_ext1 | input | 8 | Second extension byte |
| req_x | input | 16 | Index register X |
| req_y | input | 16 | Index register Y |
| req_sp | input | 16 | Stack pointer |
| req_pc | input | 16 | Address of the postbyte |
| req_acc_a | input | 8 | Accumulator A (high half of D) |
| req_acc_b | input | 8 | Accumulator B (low half of D) |
| req_lea | input | 1 | Load the address into an index register |
| req_lea_dst | input | 2 | Load target: 00 X, 01 Y, 10 SP |
| rd_valid | output | 1 | Byte read request |
| rd_ready | input | 1 | Read completes this cycle |
| rd_addr | output | 16 | Byte read address |
| rd_data | input | 8 | Byte returned on the read handshake |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_ea | output | 16 | Effective address |
| res_ext_cnt | output | 2 | Extension bytes used (0, 1 or 2) |
| res_wb_en | output | 1 | Base register writeback enable |
| res_wb_sel | output | 2 | Writeback register (00 X, 01 Y, 10 SP) |
| res_wb_val | output | 16 | Writeback value |
| res_lea_en | output | 1 | Load of the address into an index register |
| res_lea_sel | output | 2 | Register receiving the load |
| res_illegal | output | 1 | Illegal load target requested |

## Verification
The assertions check the channel rules on every cycle: result and read values hold steady under back-pressure, a read and a result are never offered together, and the second indirect read goes to the address after the first. They also check that a writeback never targets PC, that a load and a writeback never hit the same register, and that a load is never granted together with the illegal flag. The address arithmetic can only be shown by the bench's scenarios: every postbyte decode, the sign handling of each offset width, the pre and post update semantics, the PC adjustment and the wrap at 2^16. The bench sweeps all 256 postbytes against a behavioural model, using random registers and corner register values, with random stalls on both the read and the result channels.

// File: rtl/ieag_pkg.sv
package ieag_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    K_DIRECT   = 2'd0,
    K_AUTO     = 2'd1,
    K_INDIRECT = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    B_X  = 2'd0,
    B_Y  = 2'd1,
    B_SP = 2'd2,
    B_PC = 2'd3
  } base_e;
endpackage

// File: rtl/ieag_decode.sv
module ieag_decode
  import ieag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [7:0]      pb,
  input  logic [AW/2-1:0] ext0,
  input  logic [AW/2-1:0] ext1,
  input  logic [AW/2-1:0] acc_a,
  input  logic [AW/2-1:0] acc_b,
  output kind_e           kind,
  output base_e           base,
  output logic [1:0]      ext_cnt,
  output logic            pre,
  output logic [AW-1:0]   offset
);
  localparam int BW = AW / 2;

  always_comb begin
    kind    = K_DIRECT;
    base    = base_e'(pb[7:6]);
    ext_cnt = 2'd0;
    pre     = 1'b0;
    offset  = {{(AW-5){pb[4]}}, pb[4:0]};
    if (pb[7:5] == 3'b111) begin
      base = base_e'(pb[4:3]);
      if (!pb[2]) begin
        if (!pb[1]) begin
          ext_cnt = 2'd1;
          offset  = {{(AW-BW){pb[0]}}, ext0};
        end else begin
          ext_cnt = 2'd2;
          offset  = {ext0, ext1};
          if (pb[0]) kind = K_INDIRECT;
        end
      end else begin
        case (pb[1:0])
          2'b00:   offset = {{(AW-BW){1'b0}}, acc_a};
          2'b01:   offset = {{(AW-BW){1'b0}}, acc_b};
          2'b10:   offset = {acc_a, acc_b};
          default: begin
            offset = {acc_a, acc_b};
            kind   = K_INDIRECT;
          end
        endcase
      end
    end else if (pb[5]) begin
      kind = K_AUTO;
      pre  = !pb[4];
      if (pb[3]) offset = {{(AW-4){1'b1}}, pb[3:0]};
      else       offset = {{(AW-4){1'b0}}, pb[3:0]} + AW'(1);
    end
  end
endmodule

// File: rtl/ieag_addr.sv
module ieag_addr
  import ieag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  kind_e         kind,
  input  base_e         base,
  input  logic [1:0]    ext_cnt,
  input  logic          pre,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] sum,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] base_val;

  always_comb begin
    case (base)
      B_X:     base_val = x;
      B_Y:     base_val = y;
      B_SP:    base_val = sp;
      default: base_val = pc + AW'(ext_cnt) + AW'(1);
    endcase
  end

  assign sum = base_val + offset;
  assign ea  = (kind == K_AUTO && !pre) ? base_val : sum;
endmodule

// File: rtl/ieag_fetch.sv
module ieag_fetch #(
  parameter int AW = ieag_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ptr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [AW/2-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] word
);
  typedef enum logic [1:0] {F_IDLE, F_HI, F_LO} fst_e;
  fst_e            st;
  logic [AW-1:0]   ptr_q;
  logic [AW/2-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          st    <= F_HI;
          ptr_q <= ptr;
        end
        F_HI: if (rd_ready) begin
          hi_q <= rd_data;
          st   <= F_LO;
        end
        default: if (rd_ready) st <= F_IDLE;
      endcase
    end
  end

  assign rd_valid = (st != F_IDLE);
  assign rd_addr  = (st == F_LO) ? ptr_q + AW'(1) : ptr_q;
  assign done     = (st == F_LO) && rd_ready;
  assign word     = {hi_q, rd_data};

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  assert_rd_next_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_HI) && rd_ready |=> rd_valid && (rd_addr == $past(rd_addr) + AW'(1)));
endmodule

// File: rtl/ieag_top.sv
module ieag_top
  import ieag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [7:0]      req_postbyte,
  input  logic [AW/2-1:0] req_ext0,
  input  logic [AW/2-1:0] req_ext1,
  input  logic [AW-1:0]   req_x,
  input  logic [AW-1:0]   req_y,
  input  logic [AW-1:0]   req_sp,
  input  logic [AW-1:0]   req_pc,
  input  logic [AW/2-1:0] req_acc_a,
  input  logic [AW/2-1:0] req_acc_b,
  input  logic            req_lea,
  input  logic [1:0]      req_lea_dst,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [AW/2-1:0] rd_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_ea,
  output logic [1:0]      res_ext_cnt,
  output logic            res_wb_en,
  output logic [1:0]      res_wb_sel,
  output logic [AW-1:0]   res_wb_val,
  output logic            res_lea_en,
  output logic [1:0]      res_lea_sel,
  output logic            res_illegal
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HOLD} st_e;
  st_e st;

  kind_e         d_kind;
  base_e         d_base;
  logic [1:0]    d_ext;
  logic          d_pre;
  logic [AW-1:0] d_off, a_sum, a_ea, f_word;
  logic          f_done, accept, lea_ok, wb_want;

  ieag_decode #(.AW(AW)) u_decode (
    .pb(req_postbyte), .ext0(req_ext0), .ext1(req_ext1),
    .acc_a(req_acc_a), .acc_b(req_acc_b),
    .kind(d_kind), .base(d_base), .ext_cnt(d_ext), .pre(d_pre), .offset(d_off)
  );

  ieag_addr #(.AW(AW)) u_addr (
    .kind(d_kind), .base(d_base), .ext_cnt(d_ext), .pre(d_pre), .offset(d_off),
    .x(req_x), .y(req_y), .sp(req_sp), .pc(req_pc), .sum(a_sum), .ea(a_ea)
  );

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign res_valid = (st == S_HOLD);
  assign lea_ok    = req_lea && (req_lea_dst != 2'b11);
  assign wb_want   = (d_kind == K_AUTO) &&
                     !(lea_ok && (req_lea_dst == 2'(d_base)));

  ieag_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(accept && d_kind == K_INDIRECT), .ptr(a_sum),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(f_done), .word(f_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      res_ea      <= '0;
      res_ext_cnt <= '0;
      res_wb_en   <= 1'b0;
      res_wb_sel  <= '0;
      res_wb_val  <= '0;
      res_lea_en  <= 1'b0;
      res_lea_sel <= '0;
      res_illegal <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          res_ea      <= a_ea;
          res_ext_cnt <= d_ext;
          res_wb_en   <= wb_want;
          res_wb_sel  <= 2'(d_base);
          res_wb_val  <= a_sum;
          res_lea_en  <= lea_ok;
          res_lea_sel <= req_lea_dst;
          res_illegal <= req_lea && !lea_ok;
          st          <= (d_kind == K_INDIRECT) ? S_FETCH : S_HOLD;
        end
        S_FETCH: if (f_done) begin
          res_ea <= f_word;
          st     <= S_HOLD;
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end

  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ea) && $stable(res_ext_cnt)
      && $stable(res_wb_en) && $stable(res_wb_val) && $stable(res_lea_en) && $stable(res_illegal));
  assert_one_channel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && res_valid));
  assert_no_pc_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wb_en |-> res_wb_sel != 2'b11);
  assert_lea_vs_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_lea_en && res_wb_en |-> res_lea_sel != res_wb_sel);
  assert_lea_not_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_lea_en && res_illegal));
  assert_ext_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ext_cnt != 2'b11);
endmodule

// File: tb/test_ieag_top.sv
`timescale 1ns/1ps
module test_ieag_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_postbyte = '0, req_ext0 = '0, req_ext1 = '0, req_acc_a = '0, req_acc_b = '0;
  logic [15:0] req_x = '0, req_y = '0, req_sp = '0, req_pc = '0;
  logic req_lea = 1'b0;
  logic [1:0] req_lea_dst = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0] rd_data;
  logic res_valid, res_ready = 1'b0;
  logic [15:0] res_ea, res_wb_val;
  logic [1:0] res_ext_cnt, res_wb_sel, res_lea_sel;
  logic res_wb_en, res_lea_en, res_illegal;

  int total = 0, fails = 0;
  int rdq[$];

  always #2 clk = ~clk;

  ieag_top i_ieag_top (.*);

  function automatic int mem_byte(int addr);
    return ((addr * 7 + 3) ^ (addr >> 8)) & 255;
  endfunction

  assign rd_data = 8'(mem_byte(int'(rd_addr)));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Memory side: random stalls on the read channel
  always @(posedge clk) begin
    #1 rd_ready = ($urandom % 3) != 0;
  end

  // Per-cycle checks of the channel rules (R10)
  logic [40:0] snap;
  logic [15:0] rd_snap;
  bit res_stall = 0, rd_stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(rd_valid && res_valid), "R10", "read and result together", 1, 0);
      if (res_stall)
        chk(res_valid && snap == {res_ea, res_ext_cnt, res_wb_en, res_wb_sel, res_wb_val,
            res_lea_en, res_lea_sel, res_illegal}, "R10", "result hold", res_ea, snap[40:25]);
      if (rd_stall)
        chk(rd_valid && rd_addr == rd_snap, "R10", "read hold", rd_addr, rd_snap);
      if (rd_valid && rd_ready) rdq.push_back(int'(rd_addr));
      res_stall = res_valid && !res_ready;
      rd_stall  = rd_valid && !rd_ready;
      snap = {res_ea, res_ext_cnt, res_wb_en, res_wb_sel, res_wb_val,
              res_lea_en, res_lea_sel, res_illegal};
      rd_snap = rd_addr;
    end
  end

  task automatic run_op(input logic [7:0] pb, e0, e1, input logic [15:0] x, y, sp, pc,
                        input logic [7:0] a, b, input logic lea, input logic [1:0] dst);
    int rr, off, n, base, upd, sum, ext, ea, wbe, wbv, ptr;
    bit ind, auto_f, got;
    string tag;
    ind = 0; auto_f = 0; n = 0; off = 0; ptr = 0;
    if (pb[7:5] == 3'b111) begin
      rr = int'(pb[4:3]);
      if (!pb[2]) begin
        if (!pb[1]) begin ext = 1; off = pb[0] ? int'(e0) - 256 : int'(e0); tag = "R2"; end
        else begin ext = 2; off = int'(e0) * 256 + int'(e1); ind = pb[0]; tag = ind ? "R6" : "R3"; end
      end else begin
        ext = 0;
        if (pb[1:0] == 2'd0) off = int'(a);
        else if (pb[1:0] == 2'd1) off = int'(b);
        else off = int'(a) * 256 + int'(b);
        ind = (pb[1:0] == 2'd3);
        tag = ind ? "R6" : "R5";
      end
    end else if (!pb[5]) begin
      rr = int'(pb[7:6]); ext = 0; tag = "R1";
      off = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
    end else begin
      rr = int'(pb[7:6]); ext = 0; tag = "R4"; auto_f = 1;
      n = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
    end
    // R7: PC-relative base points past the postbyte and its extension bytes
    base = (rr == 0) ? int'(x) : (rr == 1) ? int'(y) : (rr == 2) ? int'(sp)
         : ((int'(pc) + 1 + ext) & 16'hFFFF);
    if (rr == 3) tag = "R7";
    wbe = 0; wbv = 0;
    if (auto_f) begin
      upd = (base + n) & 16'hFFFF;   // R8 wrap
      ea = pb[4] ? base : upd;
      wbe = 1; wbv = upd;
    end else begin
      sum = (base + off) & 16'hFFFF; // R8 wrap
      if (ind) begin
        ptr = sum;
        ea = mem_byte(sum) * 256 + mem_byte((sum + 1) & 16'hFFFF);
      end else ea = sum;
    end
    if (lea && dst != 2'b11 && wbe == 1 && int'(dst) == rr) wbe = 0;

    rdq.delete();
    @(posedge clk); #1;
    req_postbyte = pb; req_ext0 = e0; req_ext1 = e1;
    req_x = x; req_y = y; req_sp = sp; req_pc = pc; req_acc_a = a; req_acc_b = b;
    req_lea = lea; req_lea_dst = dst; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    chk(!req_ready, "R10", "busy after accept", req_ready, 0);
    got = 0;
    forever begin
      @(negedge clk);
      if (res_valid && !got) begin
        got = 1;
        chk(int'(res_ea) == ea, tag, $sformatf("ea pb=%02h", pb), res_ea, ea);
        chk(int'(res_ext_cnt) == ext, tag, $sformatf("ext count pb=%02h", pb), res_ext_cnt, ext);
        chk(int'(res_wb_en) == wbe, "R4", $sformatf("wb enable pb=%02h", pb), res_wb_en, wbe);
        if (wbe == 1) begin
          chk(int'(res_wb_sel) == rr, "R4", "wb select", res_wb_sel, rr);
          chk(int'(res_wb_val) == wbv, "R4", "wb value", res_wb_val, wbv);
        end
        chk(res_lea_en == (lea && dst != 2'b11), "R9", "lea enable", res_lea_en, lea && dst != 2'b11);
        chk(res_illegal == (lea && dst == 2'b11), "R9", "illegal", res_illegal, lea && dst == 2'b11);
        if (res_lea_en) chk(res_lea_sel == dst, "R9", "lea select", res_lea_sel, dst);
        if (ind)
          chk(rdq.size() == 2 && rdq[0] == ptr && rdq[1] == ((ptr + 1) & 16'hFFFF),
              "R6", "indirect read order", rdq.size() > 0 ? rdq[0] : -1, ptr);
        else chk(rdq.size() == 0, "R6", "no read on direct form", rdq.size(), 0);
      end
      if (res_valid && res_ready) break;
      @(posedge clk); #1 res_ready = ($urandom % 2) != 0;
    end
    @(posedge clk); #1 res_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
    chk(res_valid == 1'b0, "R11", "res_valid in reset", res_valid, 0);
    chk(rd_valid == 1'b0, "R11", "rd_valid in reset", rd_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int pass = 0; pass < 4; pass++) begin
      for (int p = 0; p < 256; p++) begin
        if (pass == 2)       // R8: values near the top of the address space
          run_op(8'(p), 8'hFF, 8'hFE, 16'hFFFC, 16'hFFFF, 16'hFFF8, 16'hFFFE,
                 8'hFF, 8'hF0, ($urandom % 2) != 0, 2'($urandom));
        else if (pass == 3)  // small values, downward wrap through zero
          run_op(8'(p), 8'h80, 8'h00, 16'h0000, 16'h0003, 16'h0001, 16'h0000,
                 8'h00, 8'h7F, ($urandom % 2) != 0, 2'($urandom));
        else
          run_op(8'(p), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom % 2) != 0, 2'($urandom));
      end
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule